// File: doc/BRIEF.md
# Dual-Pointer Auto-Stepping Video Memory Access

This block sits between a CPU register bus and a byte-wide synchronous video memory with a 17-bit address space. It keeps two independent address pointers. Each pointer has its own step size and its own direction flag, and each is paired with a data register. A CPU read or write of a data register performs the memory transfer at that pointer's address. The pointer then moves by its step, forward or backward, wrapping modulo 2^17.

Read data is prefetched, so a data register always holds the byte at its pointer's current address. A CPU read returns that byte in the same cycle, and a fetch from the pointer's new address follows. Writes are queued per port and sent to memory ahead of any fetch. A write that lands on the address the other pointer is holding makes that pointer refetch. Reloading any pointer register starts a fresh prefetch.

A 16-bit CPU access to data register 0 also acts on data register 1, which carries the upper byte. If pointer 1 is set one address above pointer 0 and both step by 2, successive 16-bit accesses sweep consecutive byte pairs. Memory serves one operation per cycle and returns read data the cycle after the request. The CPU must therefore leave at least six cycles between data-register accesses.

Top module: `vmem_dual_port`

## Requirements
- R1: After reset, both pointers are 0, both step codes are 0 and both direction flags are clear, so every pointer register reads 0. Data register 0 holds the byte at address 0 once the reset prefetch completes.
- R2: The select codes for pointer 0 are 0, 1 and 2, and for pointer 1 are 3, 4 and 5. Code 3p reads and writes address bits 7:0 and code 3p+1 reads and writes bits 15:8. Code 3p+2 holds bit 0 = address bit 16, bit 3 = decrement flag and bits 7:4 = step code. Bits 2:1 of that register read 0.
- R3: Step code 0 gives a step of 0, and step code k (1..15) gives a step of 2^(k-1) addresses. A step of 0 leaves the pointer unchanged.
- R4: Every CPU read or write of data register p (select code 6+p) advances pointer p by its step. The step is added when the decrement flag is clear and subtracted when it is set.
- R5: Pointer arithmetic wraps modulo 2^17 in both directions.
- R6: A read of a data register returns the byte stored at the pointer's address before the advance.
- R7: A write to a data register stores cpu_wdata[7:0] at the pointer's address before the advance. With a step of 0, a later read of that port returns the written byte.
- R8: A write to any pointer register triggers a refetch, so the data register then holds the byte at the newly loaded address.
- R9: With cpu_wide set and select code 6, port 0 takes the low byte and port 1 takes the high byte (cpu_wdata[15:8] on writes, cpu_rdata[15:8] on reads). Both pointers advance.
- R10: A memory write at the address another pointer currently holds makes that pointer's data register refetch the new byte.
- R11: At most one memory operation is issued per cycle. Pending writes go before fetches, and port 0 goes before port 1 within each kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 3 | Register select code |
| cpu_rd | input | 1 | One-cycle read strobe |
| cpu_wr | input | 1 | One-cycle write strobe |
| cpu_wide | input | 1 | 16-bit access flag (acts with select code 6) |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data, combinational from cpu_sel |
| mem_req | output | 1 | Memory operation request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 17 | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid the cycle after a read request |

## Verification
A pointer that moves by the wrong amount or in the wrong direction shows up at the next read of its low or middle pointer register. It also shows up on the next data read, which returns a byte from the wrong address. A stale or misrouted prefetch is only visible through cpu_rdata, and only after the fetch path has finished, which takes three cycles from the access. Ordering faults in the write queue appear directly on the memory bus: the bench logs every operation of a 16-bit write and checks the order of writes and fetches. Missing refetches after a reload or after a write by the other port leave an old byte in a data register, and the bench reads it back through the normal select codes.

// File: rtl/vmp_pkg.sv
package vmp_pkg;
    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int STEP_W = 4;
    localparam int NPORT  = 2;
    localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1;

    typedef logic [ADDR_W-1:0] vaddr_t;
    typedef logic [DATA_W-1:0] vbyte_t;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              decr;
    } pcfg_t;

    typedef enum logic [2:0] {
        SEL_P0_LO  = 3'd0,
        SEL_P0_MID = 3'd1,
        SEL_P0_HI  = 3'd2,
        SEL_P1_LO  = 3'd3,
        SEL_P1_MID = 3'd4,
        SEL_P1_HI  = 3'd5,
        SEL_DATA0  = 3'd6,
        SEL_DATA1  = 3'd7
    } sel_e;

    function automatic vaddr_t step_amount(input logic [STEP_W-1:0] code);
        if (code == '0) return '0;
        return vaddr_t'(1) << (code - STEP_W'(1));
    endfunction

    function automatic vaddr_t advance(input vaddr_t a, input pcfg_t c);
        vaddr_t s;
        s = step_amount(c.step);
        return c.decr ? (a - s) : (a + s);
    endfunction
endpackage

// File: rtl/vmp_port.sv
module vmp_port
    import vmp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ld_lo,
    input  logic   ld_mid,
    input  logic   ld_hi,
    input  vbyte_t ld_data,
    input  logic   acc,
    input  logic   acc_we,
    input  vbyte_t acc_data,
    input  logic   grant_wr,
    input  logic   grant_fetch,
    input  logic   fill,
    input  vbyte_t fill_data,
    input  logic   snoop,
    output vaddr_t ptr,
    output pcfg_t  cfg,
    output vbyte_t data,
    output logic   wr_pend,
    output vaddr_t wr_addr,
    output vbyte_t wr_data,
    output logic   fetch_pend
);
    logic ld_any;
    assign ld_any = ld_lo | ld_mid | ld_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr        <= '0;
            cfg        <= '0;
            data       <= '0;
            wr_pend    <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            fetch_pend <= 1'b1;
        end else begin
            if (grant_wr) wr_pend <= 1'b0;
            if (acc && acc_we) begin
                wr_pend <= 1'b1;
                wr_addr <= ptr;
                wr_data <= acc_data;
            end
            if (grant_fetch) fetch_pend <= 1'b0;
            if (acc || ld_any || snoop) fetch_pend <= 1'b1;
            if (acc) ptr <= advance(ptr, cfg);
            if (ld_lo)  ptr[7:0]  <= ld_data;
            if (ld_mid) ptr[15:8] <= ld_data;
            if (ld_hi) begin
                ptr[ADDR_W-1] <= ld_data[0];
                cfg.decr      <= ld_data[3];
                cfg.step      <= ld_data[7:4];
            end
            if (fill) data <= fill_data;
        end
    end

    // R4
    adv_up_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !ld_any && !cfg.decr) |=> ptr == $past(ptr) + $past(step_amount(cfg.step)));
    // R4
    adv_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !ld_any && cfg.decr) |=> ptr == $past(ptr) - $past(step_amount(cfg.step)));
    // R8
    reload_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        ld_any |=> fetch_pend);
    // R7
    wr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && acc_we) |=> (wr_pend && wr_addr == $past(ptr)));
    // R6
    fill_chk: assert property (@(posedge clk) disable iff (rst)
        fill |=> data == $past(fill_data));
endmodule

// File: rtl/vmp_sched.sv
module vmp_sched
    import vmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] wr_pend,
    input  logic [NPORT-1:0] fetch_pend,
    output logic [NPORT-1:0] grant_wr,
    output logic [NPORT-1:0] grant_fetch
);
    logic taken;

    always_comb begin
        grant_wr    = '0;
        grant_fetch = '0;
        taken       = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if (!taken && wr_pend[p]) begin
                grant_wr[p] = 1'b1;
                taken       = 1'b1;
            end
        end
        for (int p = 0; p < NPORT; p++) begin
            if (!taken && fetch_pend[p]) begin
                grant_fetch[p] = 1'b1;
                taken          = 1'b1;
            end
        end
    end

    // R11
    one_op_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({grant_wr, grant_fetch}));
    // R11
    wr_first_chk: assert property (@(posedge clk) disable iff (rst)
        (|wr_pend) |-> (grant_fetch == '0 && grant_wr != '0));
endmodule

// File: rtl/vmem_dual_port.sv
module vmem_dual_port
    import vmp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          cpu_sel,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    input  logic                cpu_wide,
    input  logic [2*DATA_W-1:0] cpu_wdata,
    output logic [2*DATA_W-1:0] cpu_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int HI_SEL_OFS = 2;

    vaddr_t           ptr      [NPORT];
    pcfg_t            cfg      [NPORT];
    vbyte_t           data     [NPORT];
    vaddr_t           wr_addr  [NPORT];
    vbyte_t           wr_data  [NPORT];
    logic [NPORT-1:0] wr_pend, fetch_pend, grant_wr, grant_fetch;
    logic [NPORT-1:0] acc, fill, snoop;
    logic             wide_hit;
    logic             fl_valid;
    logic [PORT_W-1:0] fl_port;

    assign wide_hit = cpu_wide && (cpu_sel == SEL_DATA0);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic   ld_lo, ld_mid, ld_hi;
        vbyte_t acc_byte;
        assign ld_lo  = cpu_wr && (cpu_sel == 3'(3*p));
        assign ld_mid = cpu_wr && (cpu_sel == 3'(3*p + 1));
        assign ld_hi  = cpu_wr && (cpu_sel == 3'(3*p + HI_SEL_OFS));
        assign acc[p] = (cpu_rd || cpu_wr) &&
                        ((cpu_sel == 3'(SEL_DATA0 + p)) || (p == 1 && wide_hit));
        assign acc_byte = (p == 1 && wide_hit) ? cpu_wdata[2*DATA_W-1:DATA_W]
                                               : cpu_wdata[DATA_W-1:0];
        assign fill[p] = fl_valid && (fl_port == PORT_W'(p));

        vmp_port u_port (
            .clk        (clk),
            .rst        (rst),
            .ld_lo      (ld_lo),
            .ld_mid     (ld_mid),
            .ld_hi      (ld_hi),
            .ld_data    (cpu_wdata[DATA_W-1:0]),
            .acc        (acc[p]),
            .acc_we     (cpu_wr),
            .acc_data   (acc_byte),
            .grant_wr   (grant_wr[p]),
            .grant_fetch(grant_fetch[p]),
            .fill       (fill[p]),
            .fill_data  (mem_rdata),
            .snoop      (snoop[p]),
            .ptr        (ptr[p]),
            .cfg        (cfg[p]),
            .data       (data[p]),
            .wr_pend    (wr_pend[p]),
            .wr_addr    (wr_addr[p]),
            .wr_data    (wr_data[p]),
            .fetch_pend (fetch_pend[p])
        );
    end

    vmp_sched u_sched (
        .clk        (clk),
        .rst        (rst),
        .wr_pend    (wr_pend),
        .fetch_pend (fetch_pend),
        .grant_wr   (grant_wr),
        .grant_fetch(grant_fetch)
    );

    // memory request mux
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (grant_wr[p]) begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wr_addr[p];
                mem_wdata = wr_data[p];
            end
            if (grant_fetch[p]) begin
                mem_req  = 1'b1;
                mem_addr = ptr[p];
            end
        end
    end

    // cross-port coherence on writes
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            snoop[p] = 1'b0;
            for (int q = 0; q < NPORT; q++) begin
                if (q != p && grant_wr[q] && wr_addr[q] == ptr[p]) snoop[p] = 1'b1;
            end
        end
    end

    // one fetch in flight at most
    always_ff @(posedge clk) begin
        if (rst) begin
            fl_valid <= 1'b0;
            fl_port  <= '0;
        end else begin
            fl_valid <= |grant_fetch;
            fl_port  <= '0;
            for (int p = 0; p < NPORT; p++)
                if (grant_fetch[p]) fl_port <= PORT_W'(p);
        end
    end

    // CPU read mux
    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_sel)
            SEL_P0_LO:  cpu_rdata[DATA_W-1:0] = ptr[0][7:0];
            SEL_P0_MID: cpu_rdata[DATA_W-1:0] = ptr[0][15:8];
            SEL_P0_HI:  cpu_rdata[DATA_W-1:0] = {cfg[0].step, cfg[0].decr, 2'b00, ptr[0][ADDR_W-1]};
            SEL_P1_LO:  cpu_rdata[DATA_W-1:0] = ptr[1][7:0];
            SEL_P1_MID: cpu_rdata[DATA_W-1:0] = ptr[1][15:8];
            SEL_P1_HI:  cpu_rdata[DATA_W-1:0] = {cfg[1].step, cfg[1].decr, 2'b00, ptr[1][ADDR_W-1]};
            SEL_DATA0: begin
                cpu_rdata[DATA_W-1:0] = data[0];
                if (cpu_wide) cpu_rdata[2*DATA_W-1:DATA_W] = data[1];
            end
            SEL_DATA1:  cpu_rdata[DATA_W-1:0] = data[1];
            default:    cpu_rdata = '0;
        endcase
    end

    // R11
    we_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);
    // R9
    wide_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (wide_hit && cpu_wr) |=> (wr_pend[0] && wr_pend[1]));
endmodule

// File: tb/vmem_dual_port_bench.sv
module vmem_dual_port_bench;
    localparam int RAM_D = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cpu_sel = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_wide = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [16:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    logic [7:0]  ram    [RAM_D];
    logic [7:0]  shadow [RAM_D];

    int n_chk = 0, n_err = 0;
    bit log_en = 0;
    int log_n = 0;
    logic        log_we   [8];
    logic [16:0] log_addr [8];
    logic [7:0]  log_dat  [8];

    always #10 clk = ~clk;

    vmem_dual_port u_vmem_dual_port (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wide(cpu_wide), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr[9:0]];
        end
    end

    always @(negedge clk) begin
        if (log_en && mem_req && log_n < 8) begin
            log_we[log_n]   = mem_we;
            log_addr[log_n] = mem_addr;
            log_dat[log_n]  = mem_wdata;
            log_n++;
        end
    end

    function automatic logic [7:0] sh(input logic [16:0] a);
        return shadow[a[9:0]];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic [2:0] sel, input logic rd, input logic wr,
                          input logic wide, input logic [15:0] wd, output logic [15:0] rv);
        @(negedge clk);
        cpu_sel = sel; cpu_rd = rd; cpu_wr = wr; cpu_wide = wide; cpu_wdata = wd;
        #2 rv = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_wide = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic wreg(input logic [2:0] sel, input logic [15:0] wd, input logic wide = 1'b0);
        logic [15:0] d;
        access(sel, 1'b0, 1'b1, wide, wd, d);
    endtask

    task automatic rreg(input logic [2:0] sel, output logic [15:0] rv, input logic wide = 1'b0);
        access(sel, 1'b1, 1'b0, wide, 16'h0, rv);
    endtask

    task automatic set_ptr(input int p, input logic [16:0] a, input logic [3:0] code, input logic dn);
        wreg(3'(3*p),     {8'h0, a[7:0]});
        wreg(3'(3*p + 1), {8'h0, a[15:8]});
        wreg(3'(3*p + 2), {8'h0, code, dn, 2'b00, a[16]});
    endtask

    task automatic test_reset();
        logic [15:0] v;
        for (int s = 0; s < 6; s++) begin
            rreg(3'(s), v);
            chk("R1 pointer reg after reset", v, 16'h0);
        end
        rreg(3'd6, v);
        chk("R1 data0 reset prefetch", v, {8'h0, sh(17'h0)});
    endtask

    task automatic test_regmap();
        logic [15:0] v;
        wreg(3'd0, 16'h0034); wreg(3'd1, 16'h0012); wreg(3'd2, 16'h002F);
        rreg(3'd0, v); chk("R2 p0 low byte", v, 16'h0034);
        rreg(3'd1, v); chk("R2 p0 mid byte", v, 16'h0012);
        rreg(3'd2, v); chk("R2 p0 high/config masked", v, 16'h0029);
        wreg(3'd5, 16'h00C1);
        rreg(3'd5, v); chk("R2 p1 high/config", v, 16'h00C1);
    endtask

    task automatic test_read_incr();
        logic [15:0] v;
        set_ptr(0, 17'h00010, 4'd1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            rreg(3'd6, v);
            chk("R6 prefetched read", v, {8'h0, sh(17'h10 + 17'(i))});
        end
        rreg(3'd0, v); chk("R4 pointer after three reads", v, 16'h0013);
    endtask

    task automatic test_steps();
        logic [15:0] v;
        set_ptr(0, 17'h00300, 4'd4, 1'b0);
        rreg(3'd6, v);
        rreg(3'd0, v); chk("R3 step code 4 gives 8 (low)", v, 16'h0008);
        rreg(3'd1, v); chk("R3 step code 4 gives 8 (mid)", v, 16'h0003);
        set_ptr(0, 17'h00050, 4'd0, 1'b0);
        rreg(3'd6, v); chk("R3 step 0 first read", v, {8'h0, sh(17'h50)});
        rreg(3'd6, v); chk("R3 step 0 second read same byte", v, {8'h0, sh(17'h50)});
        rreg(3'd0, v); chk("R3 step 0 pointer unchanged", v, 16'h0050);
    endtask

    task automatic test_decr();
        logic [15:0] v;
        set_ptr(0, 17'h00020, 4'd3, 1'b1);
        rreg(3'd6, v); chk("R6 read before decrement", v, {8'h0, sh(17'h20)});
        rreg(3'd0, v); chk("R4 decrement by 4", v, 16'h001C);
        rreg(3'd6, v); chk("R6 read after decrement", v, {8'h0, sh(17'h1C)});
    endtask

    task automatic test_wrap();
        logic [15:0] v;
        set_ptr(0, 17'h1FFFF, 4'd1, 1'b0);
        rreg(3'd6, v); chk("R5 read at top address", v, {8'h0, sh(17'h1FFFF)});
        rreg(3'd0, v); chk("R5 wrap up low", v, 16'h0000);
        rreg(3'd2, v); chk("R5 wrap up high/config", v, 16'h0010);
        set_ptr(0, 17'h00000, 4'd2, 1'b1);
        rreg(3'd6, v);
        rreg(3'd0, v); chk("R5 wrap down low", v, 16'h00FE);
        rreg(3'd1, v); chk("R5 wrap down mid", v, 16'h00FF);
        rreg(3'd2, v); chk("R5 wrap down high/config", v, 16'h0029);
    endtask

    task automatic test_write();
        logic [15:0] v;
        set_ptr(0, 17'h00040, 4'd1, 1'b0);
        wreg(3'd6, 16'h00A5); shadow[10'h040] = 8'hA5;
        wreg(3'd6, 16'h005A); shadow[10'h041] = 8'h5A;
        rreg(3'd0, v); chk("R4 pointer after two writes", v, 16'h0042);
        set_ptr(0, 17'h00040, 4'd1, 1'b0);
        rreg(3'd6, v); chk("R8 reload shows written byte", v, {8'h0, sh(17'h40)});
        rreg(3'd6, v); chk("R7 second written byte", v, {8'h0, sh(17'h41)});
        set_ptr(0, 17'h00200, 4'd0, 1'b0);
        wreg(3'd6, 16'h003C); shadow[10'h200] = 8'h3C;
        rreg(3'd6, v); chk("R7 step 0 write visible in prefetch", v, 16'h003C);
    endtask

    task automatic test_wide();
        logic [15:0] v;
        set_ptr(0, 17'h00080, 4'd2, 1'b0);
        set_ptr(1, 17'h00081, 4'd2, 1'b0);
        log_n = 0; log_en = 1;
        wreg(3'd6, 16'hBEEF, 1'b1);
        log_en = 0;
        shadow[10'h080] = 8'hEF; shadow[10'h081] = 8'hBE;
        chk("R11 op count for 16-bit write", 32'(log_n), 32'd4);
        chk("R11 op0 write port0", {log_we[0], 7'h0, log_addr[0], log_dat[0]}, {1'b1, 7'h0, 17'h80, 8'hEF});
        chk("R11 op1 write port1", {log_we[1], 7'h0, log_addr[1], log_dat[1]}, {1'b1, 7'h0, 17'h81, 8'hBE});
        chk("R11 op2 fetch port0", {log_we[2], 7'h0, log_addr[2]}, {1'b0, 7'h0, 17'h82});
        chk("R11 op3 fetch port1", {log_we[3], 7'h0, log_addr[3]}, {1'b0, 7'h0, 17'h83});
        wreg(3'd6, 16'h1234, 1'b1);
        shadow[10'h082] = 8'h34; shadow[10'h083] = 8'h12;
        rreg(3'd0, v); chk("R9 port0 advanced by 4", v, 16'h0084);
        rreg(3'd3, v); chk("R9 port1 advanced by 4", v, 16'h0085);
        set_ptr(0, 17'h00080, 4'd2, 1'b0);
        set_ptr(1, 17'h00081, 4'd2, 1'b0);
        rreg(3'd6, v, 1'b1); chk("R9 wide read first pair", v, 16'hBEEF);
        rreg(3'd6, v, 1'b1); chk("R9 wide read second pair", v, 16'h1234);
    endtask

    task automatic test_snoop();
        logic [15:0] v;
        set_ptr(1, 17'h00100, 4'd0, 1'b0);
        set_ptr(0, 17'h00100, 4'd1, 1'b0);
        rreg(3'd7, v); chk("R10 port1 before write", v, {8'h0, sh(17'h100)});
        wreg(3'd6, 16'h0077); shadow[10'h100] = 8'h77;
        rreg(3'd7, v); chk("R10 port1 refreshed by port0 write", v, 16'h0077);
    endtask

    initial begin
        for (int i = 0; i < RAM_D; i++) begin
            ram[i]    = 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        test_reset();
        test_regmap();
        test_read_incr();
        test_steps();
        test_decr();
        test_wrap();
        test_write();
        test_wide();
        test_snoop();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule